// File: doc/BRIEF.md
# Streaming COBS Frame Decoder

This block takes a byte stream encoded with Consistent Overhead Byte Stuffing, in which the value 0x00 appears only as a frame separator, and restores the original packets on a valid/ready output stream. Each restored packet ends with `out_last_o`. A frame that ends in the middle of a segment is closed with `out_err_o` raised on its final beat, so downstream logic can discard it.

Decoding is done one byte at a time. A down-counter tracks the bytes left in the current segment, and a flag records whether a zero is owed at the segment boundary. A one-symbol hold register keeps the most recent decoded byte until the next input byte shows whether that byte ends the packet. No frame buffer is needed. The owed zero is turned into data only when the next code byte arrives, which is the point at which the frame is known to continue. For this reason a frame's final segment never produces a trailing zero.

Top module: `cobs_frame_decoder`

## Requirements
- R1: After reset, `out_valid_o` is 0 and `in_ready_o` is 1. The output never becomes valid unless an input byte was accepted in the previous cycle.
- R2: The first nonzero byte of a frame, and the first byte after each completed segment, is a code byte N. It is not output. The next N-1 bytes are output unchanged and in order.
- R3: When a segment with code below 255 is followed by another code byte in the same frame, one 0x00 beat is output between the two segments' data. When such a segment is the last one of the frame, no zero is output.
- R4: After a segment with code 255, no zero is output before the next segment's data.
- R5: Only the decoded byte that is followed by the delimiter 0x00 carries `out_last_o`=1. Accepting any nonzero input byte never produces a beat with `out_last_o`=1.
- R6: If the delimiter arrives while the current segment still expects data, the frame's final beat has `out_last_o`=1 and `out_err_o`=1. If no data was decoded, a single 0x00 beat with both flags set is output. `out_err_o`=1 appears only on a last beat.
- R7: A frame with no content (two delimiters in a row) produces no output. A frame that decodes to zero bytes without error (for example 0x01 0x00) also produces no output.
- R8: While `out_valid_o`=1 and `out_ready_i`=0, the output beat stays stable and `in_ready_o` is 0. No decoded byte is lost or duplicated under backpressure.
- R9: A 0x00 input byte always acts as a delimiter, never as data, even in the middle of a segment. The byte after it is treated as the code byte of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | SYM_W | Encoded input byte |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Decoder can accept an input byte |
| out_data_o | output | SYM_W | Decoded byte |
| out_valid_o | output | 1 | Decoded beat valid |
| out_ready_i | input | 1 | Downstream accepts the beat |
| out_last_o | output | 1 | Final beat of a packet |
| out_err_o | output | 1 | Packet was truncated (only with out_last_o) |

## Verification
The hardest case to reach from the ports is a maximum-length segment, which takes 254 literal bytes, followed directly by another segment, while the output is throttled. In that case the absence of an inserted zero must hold even though the hold register and the output register are both full. The stimulus drives a full 255-code segment both with a free-running consumer and with a consumer that refuses one cycle in three. It also drives short segments of code 1 back to back, so that an owed zero is created and consumed on consecutive bytes. Truncated frames are placed directly before a well-formed one, to show that the decoder recovers at the delimiter.

// File: rtl/cobs_dec_pkg.sv
package cobs_dec_pkg;
  typedef enum logic [1:0] {
    SYM_DELIM = 2'd0,
    SYM_CODE  = 2'd1,
    SYM_DATA  = 2'd2
  } sym_kind_e;
endpackage

// File: rtl/cobs_sym_classify.sv
module cobs_sym_classify
  import cobs_dec_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic [SYM_W-1:0] sym_i,
  input  logic             seg_done_i,
  output sym_kind_e        kind_o
);
  always_comb begin
    if (sym_i == '0)     kind_o = SYM_DELIM;
    else if (seg_done_i) kind_o = SYM_CODE;
    else                 kind_o = SYM_DATA;
  end
endmodule

// File: rtl/cobs_seg_tracker.sv
module cobs_seg_tracker
  import cobs_dec_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic [SYM_W-1:0] sym_i,
  input  sym_kind_e        kind_i,
  output logic             seg_done_o,
  output logic             emit_o,
  output logic [SYM_W-1:0] emit_sym_o,
  output logic             close_o,
  output logic             close_err_o
);
  localparam logic [SYM_W-1:0] MAX_CODE = '1;
  localparam logic [SYM_W-1:0] ONE      = SYM_W'(1);

  logic [SYM_W-1:0] rem_q, rem_d;
  logic             long_q, long_d;   // current segment has the maximum code
  logic             zpend_q, zpend_d; // zero owed if the frame continues
  logic             frame_q, frame_d; // a code byte was seen in this frame

  assign seg_done_o = (rem_q == '0);

  always_comb begin
    rem_d       = rem_q;
    long_d      = long_q;
    zpend_d     = zpend_q;
    frame_d     = frame_q;
    emit_o      = 1'b0;
    emit_sym_o  = '0;
    close_o     = 1'b0;
    close_err_o = 1'b0;
    if (take_i) begin
      unique case (kind_i)
        SYM_DELIM: begin
          close_o     = frame_q;
          close_err_o = frame_q && (rem_q != '0);
          rem_d       = '0;
          long_d      = 1'b0;
          zpend_d     = 1'b0;
          frame_d     = 1'b0;
        end
        SYM_CODE: begin
          emit_o  = zpend_q; // owed zero becomes data now
          rem_d   = sym_i - ONE;
          long_d  = (sym_i == MAX_CODE);
          zpend_d = (sym_i == ONE);
          frame_d = 1'b1;
        end
        default: begin
          emit_o     = 1'b1;
          emit_sym_o = sym_i;
          rem_d      = rem_q - ONE;
          if (rem_q == ONE) zpend_d = !long_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q   <= '0;
      long_q  <= 1'b0;
      zpend_q <= 1'b0;
      frame_q <= 1'b0;
    end else begin
      rem_q   <= rem_d;
      long_q  <= long_d;
      zpend_q <= zpend_d;
      frame_q <= frame_d;
    end
  end
endmodule

// File: rtl/cobs_out_stage.sv
module cobs_out_stage #(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             emit_i,
  input  logic [SYM_W-1:0] emit_sym_i,
  input  logic             close_i,
  input  logic             close_err_i,
  input  logic             out_ready_i,
  output logic             free_o,
  output logic             out_valid_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_last_o,
  output logic             out_err_o
);
  logic             hold_v_q;
  logic [SYM_W-1:0] hold_q;
  logic             load;
  logic [SYM_W-1:0] load_data;
  logic             load_last;
  logic             load_err;

  assign free_o = !out_valid_o || out_ready_i;

  always_comb begin
    load      = 1'b0;
    load_data = hold_q;
    load_last = 1'b0;
    load_err  = 1'b0;
    if (emit_i) begin
      load = hold_v_q;
    end else if (close_i) begin
      load      = hold_v_q || close_err_i;
      load_data = hold_v_q ? hold_q : '0;
      load_last = 1'b1;
      load_err  = close_err_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_q      <= '0;
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
      out_last_o  <= 1'b0;
      out_err_o   <= 1'b0;
    end else begin
      if (out_valid_o && out_ready_i) out_valid_o <= 1'b0;
      if (load) begin
        out_valid_o <= 1'b1;
        out_data_o  <= load_data;
        out_last_o  <= load_last;
        out_err_o   <= load_err;
      end
      if (emit_i) begin
        hold_v_q <= 1'b1;
        hold_q   <= emit_sym_i;
      end else if (close_i) begin
        hold_v_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cobs_frame_decoder.sv
module cobs_frame_decoder
  import cobs_dec_pkg::*;
#(
  parameter int SYM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SYM_W-1:0] in_data_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  output logic [SYM_W-1:0] out_data_o,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic             out_last_o,
  output logic             out_err_o
);
  sym_kind_e        kind;
  logic             seg_done;
  logic             take;
  logic             emit;
  logic [SYM_W-1:0] emit_sym;
  logic             close;
  logic             close_err;
  logic             free;

  assign in_ready_o = free;
  assign take       = in_valid_i && free;

  cobs_sym_classify #(.SYM_W(SYM_W)) u_classify (
    .sym_i      (in_data_i),
    .seg_done_i (seg_done),
    .kind_o     (kind)
  );

  cobs_seg_tracker #(.SYM_W(SYM_W)) u_tracker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .take_i      (take),
    .sym_i       (in_data_i),
    .kind_i      (kind),
    .seg_done_o  (seg_done),
    .emit_o      (emit),
    .emit_sym_o  (emit_sym),
    .close_o     (close),
    .close_err_o (close_err)
  );

  cobs_out_stage #(.SYM_W(SYM_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .emit_i      (emit),
    .emit_sym_i  (emit_sym),
    .close_i     (close),
    .close_err_i (close_err),
    .out_ready_i (out_ready_i),
    .free_o      (free),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_err_o   (out_err_o)
  );
endmodule

// File: rtl/cobs_frame_decoder_chk.sv
module cobs_frame_decoder_chk #(
  parameter int SYM_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SYM_W-1:0] in_data_i,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic [SYM_W-1:0] out_data_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic             out_last_o,
  input logic             out_err_o
);
  // R8
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_last_o) && $stable(out_err_o));

  // R6
  err_on_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_err_o |-> out_last_o);

  // R5
  data_no_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o && (in_data_i != '0) |=> !(out_valid_o && out_last_o));

  // R1
  no_spont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o) && !out_valid_o |=> !out_valid_o);
endmodule

bind cobs_frame_decoder cobs_frame_decoder_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/cobs_frame_decoder_bench.sv
module cobs_frame_decoder_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] in_data_i = 8'h00;
  logic       in_valid_i = 1'b0;
  logic       in_ready_o;
  logic [7:0] out_data_o;
  logic       out_valid_o;
  logic       out_ready_i = 1'b1;
  logic       out_last_o;
  logic       out_err_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit stall = 1'b0;
  logic [9:0] exp_q[$];

  always #10 clk_i = ~clk_i;

  cobs_frame_decoder #(.SYM_W(8)) u_cobs_frame_decoder (.*);

  task automatic check(input bit ok, input string tag, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected beat: {last, err, data}
  task automatic exp_beat(input logic [7:0] d, input logic l, input logic e);
    exp_q.push_back({l, e, d});
  endtask

  task automatic send(input logic [7:0] b);
    in_valid_i = 1'b1;
    in_data_i  = b;
    while (!in_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    in_valid_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 3000 && exp_q.size() != 0; i++) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, tag, 10'(exp_q.size()), 10'd0);
  endtask

  // consumer readiness, updated just after the rising edge
  always @(posedge clk_i) begin
    #2;
    cyc++;
    out_ready_i = stall ? (cyc % 3 != 0) : 1'b1;
  end

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (out_valid_o && !out_ready_i)
        check(!in_ready_o, "R8 in_ready during stall", {9'd0, in_ready_o}, 10'd0);
      if (out_valid_o && out_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected beat", {out_last_o, out_err_o, out_data_o}, 10'h3ff);
        end else begin
          logic [9:0] e;
          e = exp_q.pop_front();
          check({out_last_o, out_err_o, out_data_o} == e, "R2/R3/R5/R6 beat",
                {out_last_o, out_err_o, out_data_o}, e);
        end
      end
    end
  end

  task automatic run_frames(input string pass);
    // R2 R5: plain segment
    exp_beat(8'h11, 0, 0); exp_beat(8'h22, 0, 0); exp_beat(8'h33, 0, 0); exp_beat(8'h44, 1, 0);
    send(8'h05); send(8'h11); send(8'h22); send(8'h33); send(8'h44); send(8'h00);
    drain({"R2 ", pass});
    // R3: zero between short segments, none trailing
    exp_beat(8'h11, 0, 0); exp_beat(8'h22, 0, 0); exp_beat(8'h00, 0, 0); exp_beat(8'h33, 1, 0);
    send(8'h03); send(8'h11); send(8'h22); send(8'h02); send(8'h33); send(8'h00);
    drain({"R3 ", pass});
    // R3: code 1 chain
    exp_beat(8'h00, 0, 0); exp_beat(8'h00, 1, 0);
    send(8'h01); send(8'h01); send(8'h01); send(8'h00);
    drain({"R3 code1 ", pass});
    // R4: max-code segment, no zero after it
    for (int i = 1; i < 255; i++) exp_beat(8'(i), 0, 0);
    exp_beat(8'hAA, 1, 0);
    send(8'hFF);
    for (int i = 1; i < 255; i++) send(8'(i));
    send(8'h02); send(8'hAA); send(8'h00);
    drain({"R4 ", pass});
    // R6 R9: truncated with data, then recovery
    exp_beat(8'h11, 0, 0); exp_beat(8'h22, 1, 1); exp_beat(8'h55, 1, 0);
    send(8'h04); send(8'h11); send(8'h22); send(8'h00);
    send(8'h02); send(8'h55); send(8'h00);
    drain({"R6 R9 ", pass});
    // R6: truncated with no data
    exp_beat(8'h00, 1, 1);
    send(8'h03); send(8'h00);
    drain({"R6 empty ", pass});
    // R7: empty frames, then a normal one
    exp_beat(8'h77, 1, 0);
    send(8'h00); send(8'h00); send(8'h01); send(8'h00);
    send(8'h02); send(8'h77); send(8'h00);
    drain({"R7 ", pass});
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R1 reset out_valid", {9'd0, out_valid_o}, 10'd0);
    check(in_ready_o == 1'b1, "R1 reset in_ready", {9'd0, in_ready_o}, 10'd1);
    run_frames("free");
    stall = 1'b1;
    run_frames("R8 throttled");
    stall = 1'b0;
    repeat (4) @(negedge clk_i);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule